// File: doc/BRIEF.md
# Data RAM Ring/Linear Address Generator

This block turns a per-instruction word offset into a physical address for a 128-word by 24-bit single-port data RAM in a DSP datapath. Each access names one of two base pointers and gives a 7-bit offset. The block adds the chosen base to the offset modulo the RAM depth and registers the result, so the RAM sees a stable address one cycle after the request.

The two bases move in one of two ways. In circular mode they both advance by one word on every sample strobe, which gives each sample period a sliding window for delay-line style storage. The second base always stays half the RAM ahead of the first. In fixed mode the bases are pinned to the bottom and the middle of the RAM. The mode input is only sampled on a strobe, so a mode change takes effect at the next sample boundary. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `dram_agen`

## Requirements
- R1: After reset, `addr_vld` is 0 and `addr` is 0. The bases sit at their fixed-mode values, which are 0 for pointer 0 and 64 for pointer 1.
- R2: A cycle with `req_vld`=1 gives `addr` = (base[`ptr_sel`] + `offset`) mod 128 together with `addr_vld`=1 on the next clock edge. `ptr_sel`=0 picks pointer 0 and `ptr_sel`=1 picks pointer 1.
- R3: A `smp_stb` pulse with `lin_mode`=0 (circular) raises both bases by one, so base 1 stays 64 above base 0 modulo 128.
- R4: In circular mode a base at 127 wraps to 0 on the next strobe, and base + offset wraps modulo 128 with no carry out.
- R5: A `smp_stb` pulse with `lin_mode`=1 (fixed) sets base 0 to 0 and base 1 to 64. Further strobes in fixed mode keep them there.
- R6: Without a strobe the bases do not change, whatever `lin_mode` does. A change of mode is therefore first seen after the next strobe.
- R7: A cycle with `req_vld`=0 drives `addr_vld` to 0 on the next edge and leaves `addr` at its last value.
- R8: A request made in the same cycle as a strobe uses the bases as they were before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| smp_stb | input | 1 | One-cycle sample boundary pulse |
| lin_mode | input | 1 | 0 = circular bases, 1 = fixed bases; sampled on `smp_stb` |
| req_vld | input | 1 | An access is requested this cycle |
| ptr_sel | input | 1 | Base pointer used by the access (0 or 1) |
| offset | input | 7 | Word offset added to the selected base |
| addr | output | 7 | Registered RAM word address |
| addr_vld | output | 1 | `addr` holds a new address this cycle |

## Verification
Every address result appears exactly one edge after the request cycle. The bench drives the request at a falling edge, steps past one rising edge and compares `addr` and `addr_vld` at the next falling edge. A strobe changes the bases at the same edge, so the bench computes the expected address from its base model before it applies the strobe, and then updates the model. In this way the pre-strobe rule of R8 and the one-edge lag of R3, R5 and R6 are measured at the same point. After reset, the bench waits out the two synchronizer cycles before it makes its first check.

// File: rtl/dram_agen_pkg.sv
package dram_agen_pkg;

  // number of base pointers served by the generator
  localparam int unsigned NUM_PTR = 2;

  typedef enum logic {
    PTR_LOW  = 1'b0,
    PTR_HIGH = 1'b1
  } ptr_id_e;

  typedef enum logic {
    MODE_RING  = 1'b0,
    MODE_FIXED = 1'b1
  } base_mode_e;

endpackage

// File: rtl/dram_agen_rst_sync.sv
module dram_agen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dram_agen_base.sv
module dram_agen_base
  import dram_agen_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_stb,
  input  logic                        lin_mode,
  output logic [NUM_PTR-1:0][AW-1:0]  base_o
);

  localparam int unsigned DEPTH    = 1 << AW;
  localparam int unsigned SEG_SIZE = DEPTH / NUM_PTR;

  logic [NUM_PTR-1:0][AW-1:0] base_d;
  logic [NUM_PTR-1:0][AW-1:0] base_q;

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    localparam logic [AW-1:0] FIXED_VAL = AW'(k * SEG_SIZE);

    // next-state: advance in ring mode, snap to segment start in fixed mode
    always_comb begin
      if (base_mode_e'(lin_mode) == MODE_FIXED) begin
        base_d[k] = FIXED_VAL;
      end else begin
        base_d[k] = base_q[k] + AW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[k] <= FIXED_VAL;
      end else if (smp_stb) begin
        base_q[k] <= base_d[k];
      end
    end
  end

  assign base_o = base_q;

endmodule

// File: rtl/dram_agen_calc.sv
module dram_agen_calc
  import dram_agen_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_vld,
  input  logic                        ptr_sel,
  input  logic [AW-1:0]               offset,
  input  logic [NUM_PTR-1:0][AW-1:0]  base_i,
  output logic [AW-1:0]               addr_o,
  output logic                        vld_o
);

  logic [AW-1:0] addr_d;
  logic [AW-1:0] addr_q;
  logic          vld_q;

  // carry out of the AW-bit sum is dropped: modulo-depth wrap
  always_comb begin
    addr_d = base_i[ptr_sel] + offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= req_vld;
      if (req_vld) begin
        addr_q <= addr_d;
      end
    end
  end

  assign addr_o = addr_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/dram_agen.sv
module dram_agen
  import dram_agen_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              lin_mode,
  input  logic              req_vld,
  input  logic              ptr_sel,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_vld
);

  logic                           rst_sync_n;
  logic [NUM_PTR-1:0][ADDR_W-1:0] base_q;

  dram_agen_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dram_agen_base #(.AW(ADDR_W)) base_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .smp_stb  (smp_stb),
    .lin_mode (lin_mode),
    .base_o   (base_q)
  );

  dram_agen_calc #(.AW(ADDR_W)) calc_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_vld (req_vld),
    .ptr_sel (ptr_sel),
    .offset  (offset),
    .base_i  (base_q),
    .addr_o  (addr),
    .vld_o   (addr_vld)
  );

endmodule

// File: rtl/dram_agen_chk.sv
module dram_agen_chk #(
  parameter int unsigned AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic          lin_mode,
  input logic          req_vld,
  input logic          ptr_sel,
  input logic [AW-1:0] offset,
  input logic [AW-1:0] addr,
  input logic          addr_vld,
  input logic [AW-1:0] base0,
  input logic [AW-1:0] base1
);

  localparam logic [AW-1:0] HALF = AW'(1 << (AW - 1));

  // R2
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> addr_vld);

  // R2
  addr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !ptr_sel) |=> (addr == AW'($past(base0) + $past(offset))));

  // R3
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !lin_mode) |=> (base0 == AW'($past(base0) + 1'b1)));

  // R3
  base_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AW'(base1 - base0) == HALF));

  // R5
  fixed_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && lin_mode) |=> (base0 == '0 && base1 == HALF));

  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(base0) && $stable(base1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!addr_vld && $stable(addr)));

endmodule

bind dram_agen dram_agen_chk #(.AW(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .smp_stb  (smp_stb),
  .lin_mode (lin_mode),
  .req_vld  (req_vld),
  .ptr_sel  (ptr_sel),
  .offset   (offset),
  .addr     (addr),
  .addr_vld (addr_vld),
  .base0    (base_q[0]),
  .base1    (base_q[1])
);

// File: tb/dram_agen_tb_top.sv
`timescale 1ns/1ps
module dram_agen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       smp_stb;
  logic       lin_mode;
  logic       req_vld;
  logic       ptr_sel;
  logic [6:0] offset;
  logic [6:0] addr;
  logic       addr_vld;

  int checks;
  int failures;
  int mb0;
  int mb1;
  int last_addr;
  bit done;

  dram_agen #(.ADDR_W(7)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .lin_mode (lin_mode),
    .req_vld  (req_vld),
    .ptr_sel  (ptr_sel),
    .offset   (offset),
    .addr     (addr),
    .addr_vld (addr_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, result sampled at the next falling edge
  task automatic step(input bit stb, input bit req, input bit sel,
                      input int off, input string tag);
    int exp;
    smp_stb = stb;
    req_vld = req;
    ptr_sel = sel;
    offset  = 7'(off);
    exp = ((sel ? mb1 : mb0) + off) % 128;
    @(posedge clk);
    @(negedge clk);
    if (stb) begin
      if (lin_mode) begin
        mb0 = 0;
        mb1 = 64;
      end else begin
        mb0 = (mb0 + 1) % 128;
        mb1 = (mb1 + 1) % 128;
      end
    end
    if (req) begin
      check(tag, int'(addr_vld), 1);
      check(tag, int'(addr), exp);
      last_addr = exp;
    end else begin
      check({tag, "/R7"}, int'(addr_vld), 0);
      check({tag, "/R7"}, int'(addr), last_addr);
    end
    smp_stb = 1'b0;
    req_vld = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    mb0 = 0; mb1 = 64; last_addr = 0;
    rst_n = 1'b0; smp_stb = 1'b0; lin_mode = 1'b0;
    req_vld = 1'b0; ptr_sel = 1'b0; offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1", int'(addr_vld), 0);
    check("R1", int'(addr), 0);
    step(0, 1, 0, 0, "R1");
    step(0, 1, 1, 0, "R1");

    // R2: full offset sweep on both pointers at reset bases
    for (int o = 0; o < 128; o++) begin
      step(0, 1, 0, o, "R2");
      step(0, 1, 1, o, "R2");
    end

    // R7: idle cycles hold the address
    step(0, 0, 0, 5, "R7");
    step(0, 0, 1, 9, "R7");

    // R3/R4: ring mode across more than one full wrap of the bases
    lin_mode = 1'b0;
    for (int i = 0; i < 130; i++) begin
      step(1, 0, 0, 0, "R3");
      step(0, 1, 0, (i * 37) % 128, "R4");
      step(0, 1, 1, (i * 53) % 128, "R4");
      step(0, 1, 1, 127, "R4");
    end

    // R8: strobe and request in the same cycle
    step(1, 1, 0, 10, "R8");
    step(1, 1, 1, 20, "R8");
    step(0, 1, 0, 0, "R8");

    // R6: switch to fixed without a strobe: bases unchanged
    lin_mode = 1'b1;
    step(0, 1, 0, 0, "R6");
    step(0, 1, 1, 0, "R6");

    // R5: fixed mode strobe pins bases, further strobes keep them
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, "R5");
      step(0, 1, 0, 0, "R5");
      step(0, 1, 1, 0, "R5");
      check("R5", mb0, 0);
    end

    // R6: back to ring without a strobe: still pinned, then advance
    lin_mode = 1'b0;
    step(0, 1, 0, 3, "R6");
    step(0, 1, 1, 3, "R6");
    step(1, 0, 0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    step(0, 1, 1, 0, "R3");

    // R1: reset mid-run restores the fixed bases
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'(addr_vld), 0);
    check("R1", int'(addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mb0 = 0; mb1 = 64; last_addr = 0;
    step(0, 1, 0, 1, "R1");
    step(0, 1, 1, 1, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule